// File: doc/BRIEF.md
# Partitioned Row-Column Memory Array

This block is a synchronous single-port memory that holds 2^ADDR_W words of DATA_W bits. The words are stored as a two-dimensional array: each physical row holds WORDS_PER_ROW words. Rows are split evenly over NUM_BLOCKS sub-arrays. The address is not used as a flat index. It is cut into three fields. The lowest field picks the word inside a row. The middle field picks the row inside a sub-array. The top field picks the sub-array.

Each field has its own decoder, and the three decoders work side by side. The column decoder makes a one-hot select, so every bit of the output word passes through a single AND-OR level and not through a binary mux tree. The block decoder makes a one-hot enable. Only the enabled sub-array writes, and only it drives the read path. The three one-hot selects are also brought out as observation outputs.

Each clock edge is one access. When the write strobe is high, the addressed word is written. Every access also captures the addressed word into the read register, so read data appears one cycle after the address.

Top module: `mem_rowcol_array`

## Requirements
- R1: The address is split as follows: column = addr[COL_W-1:0], row-in-block = the next ROW_W bits, and block = the top BLK_W bits. With the default sizes (ADDR_W=10, 8 words per row, 2 blocks), COL_W=3, ROW_W=6 and BLK_W=1, so address 9 maps to block 0, row 1, column 1, and address 521 maps to block 1, row 1, column 1.
- R2: dbgRowSel is one-hot in the same cycle as the address, with bit index equal to the row-in-block field.
- R3: dbgColSel is one-hot in the same cycle as the address, with bit index equal to the column field.
- R4: dbgBlkEn is one-hot, with bit index equal to the block field. Only that sub-array takes part in the access.
- R5: rdData, sampled after the rising edge that captured an address, equals the word stored at that address before that edge. The read latency is one cycle.
- R6: A write changes only the addressed word. Other words in the same row, the same row position in another block, and other rows keep their contents.
- R7: A write returns, on rdData, the old contents of the address it overwrites (read-before-write). The new value is visible on the next access.
- R8: While rst_n is low, rdData is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read register |
| addr | input | ADDR_W | Word address: block, row and column fields |
| we | input | 1 | Write strobe for the current access |
| wrData | input | DATA_W | Data written when we is high |
| rdData | output | DATA_W | Registered read word |
| dbgRowSel | output | ROWS_PER_BLK | One-hot row select inside the addressed block |
| dbgColSel | output | WORDS_PER_ROW | One-hot column select |
| dbgBlkEn | output | NUM_BLOCKS | One-hot sub-array enable |

## Verification
The bench places distinct values at the two column neighbours of one address, at the same row and column in the other block, and at the same column in a different row. It then rewrites the centre word and reads every neighbour back. A decoder that drops a field or writes a whole row would corrupt one of these words, and a block enable that fails would alias the two sub-arrays. A write to an address that was just written must return the older value, which exposes a write-first read path. Reads that follow at once after a write expose any extra or missing register stage. Addresses 0 and the last address check the ends of all three decoders.

// File: rtl/mem_array_pkg.sv
package mem_array_pkg;

  localparam int DEF_DATA_W   = 16;
  localparam int DEF_ADDR_W   = 10;
  localparam int DEF_WPR      = 8;
  localparam int DEF_BLOCKS   = 2;
  localparam int DEF_ROW_W    = DEF_ADDR_W - $clog2(DEF_WPR) - $clog2(DEF_BLOCKS);
  localparam int DEF_ROWS     = 1 << DEF_ROW_W;

  // Strobes sent from the decode stage to the storage stage
  typedef struct packed {
    logic                  wrEn;
    logic [DEF_BLOCKS-1:0] blkEn;
    logic [DEF_ROWS-1:0]   rowSel;
    logic [DEF_WPR-1:0]    colSel;
  } strobeDefault_t;

endpackage

// File: rtl/mem_array_ctrl.sv
module mem_array_ctrl #(
  parameter int  ADDR_W        = mem_array_pkg::DEF_ADDR_W,
  parameter int  WORDS_PER_ROW = mem_array_pkg::DEF_WPR,
  parameter int  NUM_BLOCKS    = mem_array_pkg::DEF_BLOCKS,
  parameter type strobe_t      = mem_array_pkg::strobeDefault_t
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output strobe_t           strb
);

  localparam int COL_W        = $clog2(WORDS_PER_ROW);
  localparam int BLK_W        = $clog2(NUM_BLOCKS);
  localparam int ROW_W        = ADDR_W - COL_W - BLK_W;
  localparam int ROWS_PER_BLK = 1 << ROW_W;

  logic [COL_W-1:0] colField;
  logic [ROW_W-1:0] rowField;
  logic [BLK_W-1:0] blkField;

  assign colField = addr[COL_W-1:0];
  assign rowField = addr[COL_W +: ROW_W];
  assign blkField = addr[ADDR_W-1 -: BLK_W];

  // The three decoders run side by side
  for (genvar c = 0; c < WORDS_PER_ROW; c++) begin : g_col
    assign strb.colSel[c] = (colField == COL_W'(c));
  end

  for (genvar r = 0; r < ROWS_PER_BLK; r++) begin : g_row
    assign strb.rowSel[r] = (rowField == ROW_W'(r));
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    assign strb.blkEn[b] = (blkField == BLK_W'(b));
  end

  assign strb.wrEn = we;

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(strb.rowSel) && strb.rowSel[rowField]);              // R2
  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(strb.colSel) && strb.colSel[colField]);              // R3
  AST_BLK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(strb.blkEn) && strb.blkEn[blkField]);                // R4

endmodule

// File: rtl/mem_array_data.sv
module mem_array_data #(
  parameter int  DATA_W        = mem_array_pkg::DEF_DATA_W,
  parameter int  ADDR_W        = mem_array_pkg::DEF_ADDR_W,
  parameter int  WORDS_PER_ROW = mem_array_pkg::DEF_WPR,
  parameter int  NUM_BLOCKS    = mem_array_pkg::DEF_BLOCKS,
  parameter type strobe_t      = mem_array_pkg::strobeDefault_t
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int COL_W        = $clog2(WORDS_PER_ROW);
  localparam int BLK_W        = $clog2(NUM_BLOCKS);
  localparam int ROW_W        = ADDR_W - COL_W - BLK_W;
  localparam int ROWS_PER_BLK = 1 << ROW_W;

  logic [DATA_W-1:0] blkWord [NUM_BLOCKS];
  logic [DATA_W-1:0] rdNext;

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [DATA_W-1:0] cells   [ROWS_PER_BLK][WORDS_PER_ROW];
    logic [DATA_W-1:0] rowWord [WORDS_PER_ROW];

    // Write only the cell at the crossing of the enabled strobes
    always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS_PER_BLK; r++) begin
        for (int c = 0; c < WORDS_PER_ROW; c++) begin
          if (strb.wrEn && strb.blkEn[b] && strb.rowSel[r] && strb.colSel[c]) begin
            cells[r][c] <= wrData;
          end
        end
      end
    end

    // Row select: the whole selected row reaches the column stage
    always_comb begin
      for (int c = 0; c < WORDS_PER_ROW; c++) begin
        rowWord[c] = '0;
        for (int r = 0; r < ROWS_PER_BLK; r++) begin
          if (strb.rowSel[r]) rowWord[c] = rowWord[c] | cells[r][c];
        end
      end
    end

    // Single-level one-hot column select, gated by the block enable
    always_comb begin
      blkWord[b] = '0;
      for (int c = 0; c < WORDS_PER_ROW; c++) begin
        if (strb.colSel[c] && strb.blkEn[b]) blkWord[b] = blkWord[b] | rowWord[c];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    for (int b = 0; b < NUM_BLOCKS; b++) rdNext = rdNext | blkWord[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdData <= '0;
    else        rdData <= rdNext;
  end

  // Cycles since reset, saturating, so that $past depth 2 stays valid
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && $past(strb.wrEn, 2) && !$past(strb.wrEn)
     && $past(strb.blkEn, 2) == $past(strb.blkEn)
     && $past(strb.rowSel, 2) == $past(strb.rowSel)
     && $past(strb.colSel, 2) == $past(strb.colSel))
    |-> rdData == $past(wrData, 2));                              // R5

  AST_IDLE_BLOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.blkEn[0] |-> blkWord[0] == '0);                         // R4

endmodule

// File: rtl/mem_rowcol_array.sv
module mem_rowcol_array #(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 10,
  parameter int WORDS_PER_ROW = 8,
  parameter int NUM_BLOCKS    = 2,
  localparam int COL_W        = $clog2(WORDS_PER_ROW),
  localparam int BLK_W        = $clog2(NUM_BLOCKS),
  localparam int ROW_W        = ADDR_W - COL_W - BLK_W,
  localparam int ROWS_PER_BLK = 1 << ROW_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     we,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [ROWS_PER_BLK-1:0]  dbgRowSel,
  output logic [WORDS_PER_ROW-1:0] dbgColSel,
  output logic [NUM_BLOCKS-1:0]    dbgBlkEn
);

  typedef struct packed {
    logic                     wrEn;
    logic [NUM_BLOCKS-1:0]    blkEn;
    logic [ROWS_PER_BLK-1:0]  rowSel;
    logic [WORDS_PER_ROW-1:0] colSel;
  } strobe_t;

  strobe_t strb;

  mem_array_ctrl #(
    .ADDR_W(ADDR_W), .WORDS_PER_ROW(WORDS_PER_ROW),
    .NUM_BLOCKS(NUM_BLOCKS), .strobe_t(strobe_t)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .strb(strb)
  );

  mem_array_data #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS_PER_ROW(WORDS_PER_ROW),
    .NUM_BLOCKS(NUM_BLOCKS), .strobe_t(strobe_t)
  ) u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData), .rdData(rdData)
  );

  assign dbgRowSel = strb.rowSel;
  assign dbgColSel = strb.colSel;
  assign dbgBlkEn  = strb.blkEn;

endmodule

// File: tb/tb_mem_rowcol_array.sv
`timescale 1ns/1ps
module tb_mem_rowcol_array;

  localparam int DW = 16;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic [63:0]   dbgRowSel;
  logic [7:0]    dbgColSel;
  logic [1:0]    dbgBlkEn;

  int nCmp = 0;
  int nBad = 0;
  logic [DW-1:0] model [int];

  always #2 clk = ~clk;

  mem_rowcol_array dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wrData(wrData),
    .rdData(rdData), .dbgRowSel(dbgRowSel), .dbgColSel(dbgColSel), .dbgBlkEn(dbgBlkEn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h (addr %0d)", req, act, exp, addr);
    end
  endtask

  // One access: drive at negedge, check decode, clock, check read word
  task automatic access(input int a, input bit w, input logic [DW-1:0] d, input string req);
    logic [DW-1:0] expRd;
    bit known;
    addr = AW'(a); we = w; wrData = d;
    #1;
    check("R1/R2 row", dbgRowSel, 64'(1) << ((a >> 3) & 63));
    check("R1/R3 col", 64'(dbgColSel), 64'(1) << (a & 7));
    check("R1/R4 blk", 64'(dbgBlkEn), 64'(1) << ((a >> 9) & 1));
    known = model.exists(a);
    if (known) expRd = model[a];
    else       expRd = '0;
    if (w) model[a] = d;
    @(posedge clk);
    @(negedge clk);
    if (known) check(req, 64'(rdData), 64'(expRd));
  endtask

  initial begin
    #(4ns * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; we = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    check("R8 reset read", 64'(rdData), 64'h0);
    rst_n = 1'b1;

    // R1 field map: address 9 -> block 0, row 1, column 1; 521 -> block 1
    access(9,   1, 16'hA5A5, "R5");
    access(8,   1, 16'h1111, "R5");
    access(10,  1, 16'h2222, "R5");
    access(521, 1, 16'h3333, "R5");
    access(1,   1, 16'h4444, "R5");
    access(9,   0, 16'h0000, "R5 read after write");
    // R7: overwrite returns old contents, new value on next access
    access(9,   1, 16'h5A5A, "R7 read-before-write");
    access(9,   0, 16'h0000, "R7 new value visible");
    // R6: neighbours untouched
    access(8,   0, 16'h0000, "R6 left column neighbour");
    access(10,  0, 16'h0000, "R6 right column neighbour");
    access(521, 0, 16'h0000, "R6 other block same row/col");
    access(1,   0, 16'h0000, "R6 other row same col");

    // Decoder ends
    access(0,    1, 16'hBEEF, "R5");
    access(1023, 1, 16'hCAFE, "R5");
    access(0,    0, 16'h0000, "R5 lowest address");
    access(1023, 0, 16'h0000, "R5 highest address");

    // Scattered pattern, then read back in a different order
    for (int i = 0; i < 48; i++) access((i * 37 + 5) % 1024, 1, DW'(i * 613 + 7), "R7");
    for (int i = 47; i >= 0; i--) access((i * 37 + 5) % 1024, 0, '0, "R5/R6 readback");
    for (int i = 0; i < 16; i++) access(i * 64 + 3, 0, '0, "R6 sweep");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule